// File: doc/BRIEF.md
# Video Line Longword Pixel Packer

The packer takes the decoded pixel stream of a video line and assembles it into 32-bit longwords for a frame-buffer write port. Pixels are two bytes wide in the colour formats (RGB or YUV) and one byte wide in the gray format. Each word leaves through a registered output with a single-cycle qualifier strobe whose active level is programmable. The word also carries a flag telling the store whether it belongs to interlaced storage.

A line opens with a `lineStart` pulse. That pulse samples every configuration input and the identity of the current field, and those values hold until the line closes. A two-bit alignment code places black pad positions ahead of the line's first pixel, and a field-mode code can drop odd or even fields. A pulse on `lineEnd` flushes a partly filled word with black in its trailing positions. A transparent mode skips packing and forwards each pixel on its own.

Top module: `line_packer`

## Requirements
- R1: Two-byte formats (`cfgGray`=0, `cfgThru`=0): each word holds two pixels. The earlier pixel sits in bits 31..16 and the later one in bits 15..0.
- R2: Two-byte formats: alignment codes 00 and 01 put the first pixel of a line in bits 31..16. Codes 10 and 11 put black in bits 31..16 and the first pixel in bits 15..0. Black is 0x0000 for RGB (`cfgYuv`=0). For YUV (`cfgYuv`=1) it is 0x1080, with luma in pixel bits 15..8 and chroma in bits 7..0.
- R3: Gray format with `cfgExt`=0: each word holds four pixels taken from `pixData[7:0]`, earliest in bits 31..24. Alignment codes 0, 1, 2 and 3 put that many 0x00 bytes ahead of the first pixel.
- R4: Gray format with `cfgExt`=1: each word holds two pixels in bits 31..16, earliest in bits 31..24. Bits 15..0 are zero. Alignment bit 0 set adds one black byte ahead of the first pixel, and alignment bit 1 has no effect.
- R5: On `lineEnd`, a word that holds at least one pixel of the line but is not yet full is emitted with black in its unused trailing positions. A pixel that arrives in the same cycle as `lineEnd` is included. A line without pixels emits nothing.
- R6: Field mode 10 keeps only lines with `fieldOdd`=1, and field mode 11 keeps only lines with `fieldOdd`=0. Modes 00 and 01 keep every line. Pixels of a dropped line never raise the qualifier. `wordInterlaced` is 1 on words of lines started in mode 00 and 0 otherwise.
- R7: With `cfgThru`=1, each accepted pixel appears unchanged as `{16'h0000, pixData}` one cycle later with one qualifier pulse. Field selection still applies.
- R8: The qualifier is active for exactly one cycle per word, in the cycle after the pixel or `lineEnd` that completes the word. It is active-high when `qualPolHigh`=1 and active-low when `qualPolHigh`=0.
- R9: Configuration is sampled at `lineStart`, so input changes during a line have no effect. Pixels that arrive outside a line (after `lineEnd` and before the next `lineStart`) are ignored.
- R10: Synchronous active-high `rst` clears the packing state and `wordOut` and leaves the qualifier at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStart | input | 1 | Opens a line and samples configuration |
| lineEnd | input | 1 | Closes a line and flushes a partial word |
| fieldOdd | input | 1 | Field identity, 1 = odd field |
| pixValid | input | 1 | Pixel present on pixData |
| pixData | input | 16 | Pixel; gray uses bits 7..0 |
| cfgGray | input | 1 | 1 = one-byte gray, 0 = two-byte colour |
| cfgYuv | input | 1 | Two-byte colour is YUV (selects black value) |
| cfgExt | input | 1 | Gray with two pixels per word |
| cfgThru | input | 1 | Transparent forwarding |
| cfgAlign | input | 2 | Leading pad code |
| cfgFieldMode | input | 2 | Field selection and storage mode |
| qualPolHigh | input | 1 | Qualifier polarity, 1 = active high |
| wordOut | output | 32 | Packed longword |
| wordQual | output | 1 | Word qualifier strobe |
| wordInterlaced | output | 1 | Word belongs to interlaced storage |

## Verification
Directed lines cover every alignment code in each of the three packed layouts, with pixel counts that end exactly on a word boundary and counts that leave a partial word. These lines separate pad errors from flush errors and from errors in the position of the bytes. Further lines cover a pixel that coincides with `lineEnd`, empty lines and dropped fields of each parity. Transparent lines and stray pixels between lines check that forwarding and idle behaviour stay apart from packing. Random lines scramble the configuration inputs after `lineStart`, so any use of live configuration in place of the sampled values shows up as wrong words.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] LUMA_BLACK   = 8'h10;
  localparam logic [BYTE_W-1:0] CHROMA_BLACK = 8'h80;

  typedef struct packed {
    logic       gray;
    logic       yuv;
    logic       ext;
    logic       thru;
    logic [1:0] align;
    logic [1:0] fmode;
  } cfgT;

  typedef struct packed {
    logic       clearAcc;
    logic       writePix;
    logic [1:0] slot;
    logic       emitPacked;
    logic       emitThru;
    logic       tagInter;
  } ctrlT;
endpackage

// File: rtl/pk_ctrl.sv
module pk_ctrl
  import pk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lineStart,
  input  logic lineEnd,
  input  logic fieldOdd,
  input  logic pixValid,
  input  cfgT  cfgIn,
  output cfgT  cfgNow,
  output ctrlT ctrlBus
);
  cfgT        cfgHold;
  logic       lineLive;
  logic [1:0] slotQ;
  logic       dirty;
  logic       pixTake;
  logic [1:0] lastSlot;

  function automatic logic fieldPass(input logic [1:0] mode, input logic odd);
    case (mode)
      2'b10:   fieldPass = odd;
      2'b11:   fieldPass = !odd;
      default: fieldPass = 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] padCount(input cfgT c);
    if (c.gray && !c.ext)  padCount = c.align;
    else if (c.gray)       padCount = {1'b0, c.align[0]};
    else                   padCount = {1'b0, c.align[1]};
  endfunction

  assign cfgNow   = lineStart ? cfgIn : cfgHold;
  assign pixTake  = lineLive && !lineStart && pixValid;
  assign lastSlot = (cfgHold.gray && !cfgHold.ext) ? 2'd3 : 2'd1;

  always_comb begin
    ctrlBus          = '0;
    ctrlBus.clearAcc = lineStart;
    ctrlBus.slot     = slotQ;
    ctrlBus.tagInter = (cfgHold.fmode == 2'b00);
    if (lineLive && !lineStart) begin
      if (cfgHold.thru) begin
        ctrlBus.emitThru = pixTake;
      end else begin
        ctrlBus.writePix   = pixTake;
        ctrlBus.emitPacked = (pixTake && slotQ == lastSlot) ||
                             (lineEnd && (dirty || pixTake));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgHold  <= '0;
      lineLive <= 1'b0;
      slotQ    <= '0;
      dirty    <= 1'b0;
    end else if (lineStart) begin
      cfgHold  <= cfgIn;
      lineLive <= fieldPass(cfgIn.fmode, fieldOdd);
      slotQ    <= padCount(cfgIn);
      dirty    <= 1'b0;
    end else if (lineLive) begin
      if (lineEnd) begin
        lineLive <= 1'b0;
        slotQ    <= '0;
        dirty    <= 1'b0;
      end else if (pixTake && !cfgHold.thru) begin
        if (slotQ == lastSlot) begin
          slotQ <= '0;
          dirty <= 1'b0;
        end else begin
          slotQ <= slotQ + 2'd1;
          dirty <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pk_datapath.sv
module pk_datapath
  import pk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfgT               cfgNow,
  input  ctrlT              ctrlBus,
  input  logic [PIX_W-1:0]  pixData,
  output logic [WORD_W-1:0] wordReg,
  output logic              strobeReg,
  output logic              tagReg
);
  localparam int SLOT2_N = WORD_W / PIX_W;
  localparam logic [PIX_W-1:0] YUV_BLACK = {LUMA_BLACK, CHROMA_BLACK};

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] blackWord;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] slotMask;
  logic [WORD_W-1:0] slotData;

  generate
    for (genvar k = 0; k < SLOT2_N; k++) begin : g_black
      assign blackWord[k*PIX_W +: PIX_W] =
        (!cfgNow.gray && cfgNow.yuv) ? YUV_BLACK : '0;
    end
  endgenerate

  always_comb begin
    if (cfgNow.gray) begin
      slotMask = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << (BYTE_W * (3 - ctrlBus.slot));
      slotData = {{(WORD_W-BYTE_W){1'b0}}, pixData[BYTE_W-1:0]} << (BYTE_W * (3 - ctrlBus.slot));
    end else begin
      slotMask = {{(WORD_W-PIX_W){1'b0}}, {PIX_W{1'b1}}} << (PIX_W * (1 - ctrlBus.slot[0]));
      slotData = {{(WORD_W-PIX_W){1'b0}}, pixData} << (PIX_W * (1 - ctrlBus.slot[0]));
    end
    merged = ctrlBus.writePix ? ((acc & ~slotMask) | slotData) : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      wordReg   <= '0;
      strobeReg <= 1'b0;
      tagReg    <= 1'b0;
    end else begin
      strobeReg <= ctrlBus.emitPacked || ctrlBus.emitThru;
      if (ctrlBus.emitThru) begin
        wordReg <= {{(WORD_W-PIX_W){1'b0}}, pixData};
        tagReg  <= ctrlBus.tagInter;
      end else if (ctrlBus.emitPacked) begin
        wordReg <= merged;
        tagReg  <= ctrlBus.tagInter;
      end
      if (ctrlBus.clearAcc || ctrlBus.emitPacked) acc <= blackWord;
      else if (ctrlBus.writePix)                  acc <= merged;
    end
  end
endmodule

// File: rtl/line_packer.sv
module line_packer
  import pk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lineStart,
  input  logic        lineEnd,
  input  logic        fieldOdd,
  input  logic        pixValid,
  input  logic [15:0] pixData,
  input  logic        cfgGray,
  input  logic        cfgYuv,
  input  logic        cfgExt,
  input  logic        cfgThru,
  input  logic [1:0]  cfgAlign,
  input  logic [1:0]  cfgFieldMode,
  input  logic        qualPolHigh,
  output logic [31:0] wordOut,
  output logic        wordQual,
  output logic        wordInterlaced
);
  cfgT  cfgIn;
  cfgT  cfgNow;
  ctrlT ctrlBus;
  logic strobeReg;

  assign cfgIn = '{gray: cfgGray, yuv: cfgYuv, ext: cfgExt, thru: cfgThru,
                   align: cfgAlign, fmode: cfgFieldMode};

  pk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lineStart(lineStart), .lineEnd(lineEnd),
    .fieldOdd(fieldOdd), .pixValid(pixValid), .cfgIn(cfgIn),
    .cfgNow(cfgNow), .ctrlBus(ctrlBus)
  );

  pk_datapath u_dp (
    .clk(clk), .rst(rst), .cfgNow(cfgNow), .ctrlBus(ctrlBus),
    .pixData(pixData), .wordReg(wordOut), .strobeReg(strobeReg),
    .tagReg(wordInterlaced)
  );

  assign wordQual = qualPolHigh ? strobeReg : !strobeReg;
endmodule

// File: rtl/pk_checker.sv
module pk_checker
  import pk_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        pixValid,
  input logic        lineEnd,
  input logic        qualPolHigh,
  input logic        wordQual,
  input logic [31:0] wordOut,
  input logic        wordInterlaced,
  input cfgT         cfgNow,
  input ctrlT        ctrlBus
);
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (wordQual != qualPolHigh) && (wordOut == '0));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pixValid && !lineEnd) |=> (wordQual != qualPolHigh));

  // R4
  ext_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.emitPacked && cfgNow.gray && cfgNow.ext) |=> (wordOut[15:0] == '0));

  // R7
  thru_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlBus.emitThru |=> (wordOut[31:16] == '0) && (wordQual == qualPolHigh));

  // R6
  interlace_tag_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlBus.emitPacked |=> (wordInterlaced == $past(cfgNow.fmode == 2'b00)));
endmodule

bind line_packer pk_checker u_chk (
  .clk(clk), .rst(rst), .pixValid(pixValid), .lineEnd(lineEnd),
  .qualPolHigh(qualPolHigh), .wordQual(wordQual), .wordOut(wordOut),
  .wordInterlaced(wordInterlaced), .cfgNow(cfgNow), .ctrlBus(ctrlBus)
);

// File: tb/sim_line_packer.sv
module sim_line_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineStart = 0, lineEnd = 0, fieldOdd = 0, pixValid = 0;
  logic [15:0] pixData = '0;
  logic        cfgGray = 0, cfgYuv = 0, cfgExt = 0, cfgThru = 0;
  logic [1:0]  cfgAlign = 0, cfgFieldMode = 0;
  logic        qualPolHigh = 1;
  logic [31:0] wordOut;
  logic        wordQual, wordInterlaced;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [15:0] pix [64];
  logic [32:0] expQ [$];
  logic [32:0] gotQ [$];

  always #2 clk = ~clk;

  line_packer u0 (
    .clk(clk), .rst(rst), .lineStart(lineStart), .lineEnd(lineEnd),
    .fieldOdd(fieldOdd), .pixValid(pixValid), .pixData(pixData),
    .cfgGray(cfgGray), .cfgYuv(cfgYuv), .cfgExt(cfgExt), .cfgThru(cfgThru),
    .cfgAlign(cfgAlign), .cfgFieldMode(cfgFieldMode), .qualPolHigh(qualPolHigh),
    .wordOut(wordOut), .wordQual(wordQual), .wordInterlaced(wordInterlaced)
  );

  always @(posedge clk) begin
    #1;
    if (!rst && (wordQual === qualPolHigh)) gotQ.push_back({wordInterlaced, wordOut});
  end

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void buildExp(input int n, input bit odd, input bit g, input bit y,
                                   input bit e, input bit t, input bit [1:0] a, input bit [1:0] fm);
    int nsl, pad, total, nw, idx;
    logic [15:0] blk;
    logic [31:0] w;
    logic [15:0] v;
    bit tag;
    expQ.delete();
    if (fm == 2 && !odd) return;
    if (fm == 3 && odd) return;
    tag = (fm == 0);
    if (t) begin
      for (int i = 0; i < n; i++) expQ.push_back({tag, 16'h0000, pix[i]});
      return;
    end
    if (n == 0) return;
    nsl = (g && !e) ? 4 : 2;
    pad = (g && !e) ? int'(a) : (g ? int'(a[0]) : int'(a[1]));
    blk = (!g && y) ? 16'h1080 : 16'h0000;
    total = pad + n;
    nw = (total + nsl - 1) / nsl;
    for (int wi = 0; wi < nw; wi++) begin
      w = '0;
      for (int s = 0; s < nsl; s++) begin
        idx = wi * nsl + s - pad;
        v = (idx >= 0 && idx < n) ? pix[idx] : blk;
        if (g) w[31 - 8*s -: 8] = v[7:0];
        else   w[31 - 16*s -: 16] = v;
      end
      expQ.push_back({tag, w});
    end
  endfunction

  task automatic runLine(input string req, input int n, input bit odd, input bit g, input bit y,
                         input bit e, input bit t, input bit [1:0] a, input bit [1:0] fm,
                         input bit endWithPix);
    for (int i = 0; i < n; i++) pix[i] = 16'($urandom);
    buildExp(n, odd, g, y, e, t, a, fm);
    gotQ.delete();
    @(negedge clk);
    cfgGray = g; cfgYuv = y; cfgExt = e; cfgThru = t; cfgAlign = a; cfgFieldMode = fm;
    fieldOdd = odd; lineStart = 1;
    @(negedge clk);
    lineStart = 0;
    // R9: scramble configuration after it has been sampled
    {cfgGray, cfgYuv, cfgExt, cfgThru, cfgAlign, cfgFieldMode, fieldOdd} = 9'($urandom);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < int'($urandom_range(0, 2)); k++) @(negedge clk);
      pixValid = 1; pixData = pix[i];
      if (i == n - 1 && endWithPix) lineEnd = 1;
      @(negedge clk);
      pixValid = 0; lineEnd = 0;
    end
    if (!endWithPix || n == 0) begin
      lineEnd = 1;
      @(negedge clk);
      lineEnd = 0;
    end
    repeat (3) @(negedge clk);
    check(gotQ.size() == expQ.size(), {req, " word count"}, 33'(gotQ.size()), 33'(expQ.size()));
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] === expQ[i], req, gotQ[i], expQ[i]);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7193));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(wordOut == 32'h0 && wordQual == 1'b0, "R10 reset high pol", {wordQual, wordOut}, 33'h0);
    qualPolHigh = 0; #1;
    check(wordQual == 1'b1, "R10 reset low pol", 33'(wordQual), 33'h1);
    qualPolHigh = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);

    // R9: stray pixels before any line are ignored
    gotQ.delete();
    repeat (4) begin pixValid = 1; pixData = 16'hBEEF; @(negedge clk); end
    pixValid = 0; repeat (2) @(negedge clk);
    check(gotQ.size() == 0, "R9 stray pixels", 33'(gotQ.size()), 33'h0);

    // R1 R2: two-byte layouts, every alignment
    for (int a = 0; a < 4; a++) begin
      runLine("R1 R2 rgb full", 4, 0, 0, 0, 0, 0, 2'(a), 2'b00, 0);
      runLine("R2 yuv partial", 3, 1, 0, 1, 0, 0, 2'(a), 2'b01, 0);
    end
    // R3: gray four per word, every alignment
    for (int a = 0; a < 4; a++) begin
      runLine("R3 gray", 5, 0, 1, 1, 0, 0, 2'(a), 2'b00, 0);
      runLine("R3 gray even", 8, 1, 1, 0, 0, 0, 2'(a), 2'b01, 0);
    end
    // R4: gray extended, alignment MSB ignored
    for (int a = 0; a < 4; a++) runLine("R4 gray ext", 3, 0, 1, 0, 1, 0, 2'(a), 2'b00, 0);
    // R5: pixel on lineEnd, empty line, pad-only line
    runLine("R5 end with pixel", 5, 0, 1, 0, 0, 0, 2'd1, 2'b00, 1);
    runLine("R5 yuv end with pixel", 1, 0, 0, 1, 0, 0, 2'd2, 2'b00, 1);
    runLine("R5 empty line", 0, 0, 0, 0, 0, 0, 2'd3, 2'b00, 0);
    // R6: field selection
    runLine("R6 odd only drop even", 6, 0, 0, 0, 0, 0, 2'd0, 2'b10, 0);
    runLine("R6 odd only keep odd", 6, 1, 0, 0, 0, 0, 2'd0, 2'b10, 0);
    runLine("R6 even only drop odd", 6, 1, 1, 0, 0, 0, 2'd1, 2'b11, 0);
    runLine("R6 even only keep even", 6, 0, 1, 0, 0, 0, 2'd1, 2'b11, 0);
    // R7: transparent
    runLine("R7 thru", 5, 0, 0, 1, 0, 1, 2'd3, 2'b00, 1);
    runLine("R7 thru dropped", 4, 1, 0, 0, 0, 1, 2'd0, 2'b11, 0);
    // R8: active-low qualifier
    qualPolHigh = 0;
    runLine("R8 low polarity", 7, 0, 0, 0, 0, 0, 2'd0, 2'b01, 0);
    runLine("R8 low polarity gray", 9, 0, 1, 0, 0, 0, 2'd2, 2'b00, 0);
    qualPolHigh = 1;

    // R9: stray pixels after lineEnd
    gotQ.delete();
    repeat (5) begin pixValid = 1; pixData = 16'h1234; @(negedge clk); end
    pixValid = 0; repeat (2) @(negedge clk);
    check(gotQ.size() == 0, "R9 pixels after line end", 33'(gotQ.size()), 33'h0);

    // random lines
    for (int r = 0; r < 60; r++) begin
      qualPolHigh = 1'($urandom);
      runLine("R1 R3 R5 random", int'($urandom_range(0, 20)), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), 2'($urandom),
              2'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule